// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block sits between a small 8-bit processor core and an external system bus. On that bus the low address byte and the data byte travel on one shared set of lines. The high address byte has lines of its own. The core raises a request carrying a 16-bit address, a direction, a space select (IO or memory) and, for writes, a data byte. The block then runs a fixed three-state bus cycle.

In the first state the full address is driven and a latch strobe pulses, so that external logic can catch the low byte. In the second and third states the shared lines carry data. On a write the block drives the data and holds the write strobe low. On a read it releases the lines, holds the read strobe low, and samples the lines as the third state closes. A single-cycle completion pulse then returns to the core together with the read byte.

An arbiter can ask the block to float its pins. The request is granted only between bus cycles. While it is granted, every pin enable is low, so that another master can use the bus. The bidirectional lines are presented to the pad ring as separate out, enable and in vectors.

Top module: `mux_bus_ctrl`

## Requirements
- R1: After reset the block is idle: ale=0, rd_n=1, wr_n=1, ad_oe=0, rsp_done=0, rsp_rdata=0, float_ack=0, io_sel=0, and addr_hi_oe=1, ctl_oe=1.
- R2: A request seen in an idle cycle enters phase T1 at the next clock edge. For that one cycle only, ale=1, ad_oe=1, ad_out is address bits [7:0], and addr_hi is address bits [15:8].
- R3: io_sel equals the request's space bit for the whole cycle: 1 selects IO space, 0 selects memory space.
- R4: On a write (req_wr=1), phases T2 and T3 have ad_oe=1, ad_out equal to the write byte, wr_n=0 and rd_n=1.
- R5: On a read (req_wr=0), phases T2 and T3 have ad_oe=0, rd_n=0 and wr_n=1. The value on ad_in at the edge closing T3 appears on rsp_rdata in the following cycle, together with rsp_done=1.
- R6: rd_n and wr_n are never low together. Each falls only in the cycle right after a T1, and both are high outside T2 and T3.
- R7: The request fields are captured on entry to T1. Changing them later has no effect on the cycle in progress.
- R8: rsp_done is high for exactly one cycle. No cycle starts from the cycle in which rsp_done is high, even when req_valid stays high; the next one starts one idle cycle later.
- R9: When float_req is seen while the block is idle, float_ack goes to 1 and addr_hi_oe, ad_oe and ctl_oe go to 0 at the next edge. A request arriving in the same cycle does not start.
- R10: When float_req rises during a bus cycle, that cycle completes with its pins driven. float_ack rises on the same edge as rsp_done.
- R11: While float_ack=1 no cycle starts. After float_req falls, float_ack drops at the next edge, and a pending request enters T1 at the edge after that.
- R12: rsp_rdata changes only on read completion. A write leaves the last read byte in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Core request, held until rsp_done |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = IO space, 0 = memory space |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Last byte read |
| float_req | input | 1 | Arbiter request to release the bus |
| float_ack | output | 1 | Bus released |
| addr_hi | output | 16-8 = 8 | High address byte |
| addr_hi_oe | output | 1 | Enable for addr_hi pads |
| ad_out | output | 8 | Shared lines, outgoing value |
| ad_oe | output | 1 | Enable for shared-line pads |
| ad_in | input | 8 | Shared lines, incoming value |
| ale | output | 1 | Address latch strobe, high in T1 |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_sel | output | 1 | Space select, 1 = IO |
| ctl_oe | output | 1 | Enable for ale, rd_n, wr_n, io_sel pads |

## Verification
Two events can land on the same clock edge: the close of a bus cycle (rsp_done with its read byte) and the grant of a float request. The bench provokes this by raising float_req while a write is still in T1. It then confirms three things: pins stay driven through T2 and T3 with float_ack low; rsp_done and float_ack rise together on the edge after T3; and all enables are low from that point. Separately, a float request raised in the same cycle as a fresh core request is judged by checking that no latch strobe ever appears until the float is withdrawn.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

  localparam int unsigned MBC_ADDR_W = 16;
  localparam int unsigned MBC_DATA_W = 8;

  // Bus cycle phase; T1 carries the address, T2/T3 carry data.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_T1   = 2'd1,
    PH_T2   = 2'd2,
    PH_T3   = 2'd3
  } bus_ph_e;

endpackage

// File: rtl/mbc_rst_sync.sv
module mbc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/mbc_seq.sv
module mbc_seq
  import mbc_pkg::*;
#(
  parameter int unsigned ADDR_W = MBC_ADDR_W,
  parameter int unsigned DATA_W = MBC_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_wr,
  input  logic              req_io,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              float_req,
  input  logic              done_q,
  output bus_ph_e           state_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              wr_q,
  output logic              io_q,
  output logic              floated_q
);

  bus_ph_e state_d;
  logic    start;
  logic    load_en;
  logic    float_en;
  logic    floated_d;

  // A new cycle needs an idle bus, no float pending or granted, and no
  // completion pulse in flight.
  always_comb begin
    start = (state_q == PH_IDLE) && req_valid && !floated_q &&
            !float_req && !done_q;
    load_en = start;
    state_d = state_q;
    unique case (state_q)
      PH_IDLE: if (start) state_d = PH_T1;
      PH_T1:   state_d = PH_T2;
      PH_T2:   state_d = PH_T3;
      PH_T3:   state_d = PH_IDLE;
      default: state_d = PH_IDLE;
    endcase
  end

  // Float state may only change at a cycle boundary.
  always_comb begin
    float_en  = (state_q == PH_IDLE) || (state_q == PH_T3);
    floated_d = float_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      floated_q <= 1'b0;
    end else if (float_en) begin
      floated_q <= floated_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      io_q    <= 1'b0;
    end else if (load_en) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      wr_q    <= req_wr;
      io_q    <= req_io;
    end
  end

  // Captured request is frozen through the address and first data phase.
  assert_req_latched_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == PH_T1) || (state_q == PH_T2)) |=> ($stable(addr_q) && $stable(wr_q) && $stable(io_q)));

  // A granted float blocks any cycle start.
  assert_float_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (floated_q && (state_q == PH_IDLE)) |=> (state_q == PH_IDLE));

  // Float is granted only on a cycle boundary.
  assert_float_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(floated_q) |-> (($past(state_q) == PH_IDLE) || ($past(state_q) == PH_T3)));

endmodule

// File: rtl/mbc_drive.sv
module mbc_drive
  import mbc_pkg::*;
#(
  parameter int unsigned ADDR_W = MBC_ADDR_W,
  parameter int unsigned DATA_W = MBC_DATA_W,
  localparam int unsigned HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_ph_e           state_q,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] wdata_q,
  input  logic              wr_q,
  input  logic              io_q,
  input  logic              floated_q,
  output logic [HI_W-1:0]   addr_hi,
  output logic              addr_hi_oe,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              io_sel,
  output logic              ctl_oe
);

  logic addr_ph;
  logic data_ph;

  always_comb begin
    addr_ph    = (state_q == PH_T1);
    data_ph    = (state_q == PH_T2) || (state_q == PH_T3);
    addr_hi    = addr_q[ADDR_W-1:DATA_W];
    addr_hi_oe = !floated_q;
    ad_out     = addr_ph ? addr_q[DATA_W-1:0] : wdata_q;
    ad_oe      = !floated_q && (addr_ph || (data_ph && wr_q));
    ale        = addr_ph;
    rd_n       = !(data_ph && !wr_q);
    wr_n       = !(data_ph && wr_q);
    io_sel     = io_q;
    ctl_oe     = !floated_q;
  end

  assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  assert_rd_after_ale_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> $past(ale));

  assert_wr_after_ale_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> $past(ale));

  assert_wr_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe);

endmodule

// File: rtl/mbc_capture.sv
module mbc_capture
  import mbc_pkg::*;
#(
  parameter int unsigned DATA_W = MBC_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_ph_e           state_q,
  input  logic              wr_q,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] rdata_q,
  output logic              done_q
);

  logic cap_en;
  logic done_d;

  always_comb begin
    done_d = (state_q == PH_T3);
    cap_en = done_d && !wr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (cap_en) begin
      rdata_q <= ad_in;
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_rdata_on_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata_q) |-> done_q);

endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
  import mbc_pkg::*;
#(
  parameter int unsigned ADDR_W     = MBC_ADDR_W,
  parameter int unsigned DATA_W     = MBC_DATA_W,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_wr,
  input  logic                     req_io,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rsp_done,
  output logic [DATA_W-1:0]        rsp_rdata,
  input  logic                     float_req,
  output logic                     float_ack,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic                     addr_hi_oe,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  input  logic [DATA_W-1:0]        ad_in,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     io_sel,
  output logic                     ctl_oe
);

  logic              srst_n;
  bus_ph_e           state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              wr_q;
  logic              io_q;
  logic              floated_q;
  logic              done_q;
  logic [DATA_W-1:0] rdata_q;

  mbc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  mbc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (srst_n),
    .req_valid (req_valid),
    .req_wr    (req_wr),
    .req_io    (req_io),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .float_req (float_req),
    .done_q    (done_q),
    .state_q   (state_q),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q),
    .wr_q      (wr_q),
    .io_q      (io_q),
    .floated_q (floated_q)
  );

  mbc_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drv (
    .clk        (clk),
    .rst_n      (srst_n),
    .state_q    (state_q),
    .addr_q     (addr_q),
    .wdata_q    (wdata_q),
    .wr_q       (wr_q),
    .io_q       (io_q),
    .floated_q  (floated_q),
    .addr_hi    (addr_hi),
    .addr_hi_oe (addr_hi_oe),
    .ad_out     (ad_out),
    .ad_oe      (ad_oe),
    .ale        (ale),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .io_sel     (io_sel),
    .ctl_oe     (ctl_oe)
  );

  mbc_capture #(.DATA_W(DATA_W)) u_cap (
    .clk     (clk),
    .rst_n   (srst_n),
    .state_q (state_q),
    .wr_q    (wr_q),
    .ad_in   (ad_in),
    .rdata_q (rdata_q),
    .done_q  (done_q)
  );

  assign rsp_done  = done_q;
  assign rsp_rdata = rdata_q;
  assign float_ack = floated_q;

endmodule

// File: tb/sim_mux_bus_ctrl.sv
module sim_mux_bus_ctrl;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_wr;
  logic        req_io;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        rsp_done;
  logic [7:0]  rsp_rdata;
  logic        float_req;
  logic        float_ack;
  logic [7:0]  addr_hi;
  logic        addr_hi_oe;
  logic [7:0]  ad_out;
  logic        ad_oe;
  logic [7:0]  ad_in;
  logic        ale;
  logic        rd_n;
  logic        wr_n;
  logic        io_sel;
  logic        ctl_oe;

  int n_chk;
  int n_err;
  bit finished;

  mux_bus_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wr(req_wr),
    .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .float_req(float_req),
    .float_ack(float_ack), .addr_hi(addr_hi), .addr_hi_oe(addr_hi_oe),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .ale(ale), .rd_n(rd_n),
    .wr_n(wr_n), .io_sel(io_sel), .ctl_oe(ctl_oe)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // One full bus cycle; the request is presented at the current negedge.
  // hold_valid keeps req_valid high through the done cycle.
  task automatic run_cycle(input logic wr, input logic io, input logic [15:0] addr,
                           input logic [7:0] wd, input logic [7:0] dev,
                           input logic [7:0] exp_rd, input bit hold_valid);
    req_valid = 1'b1; req_wr = wr; req_io = io; req_addr = addr; req_wdata = wd;
    step(); // T1
    chk("R2 ale in T1", ale, 1);
    chk("R2 ad_oe in T1", ad_oe, 1);
    chk("R2 low address", ad_out, addr[7:0]);
    chk("R2 high address", addr_hi, addr[15:8]);
    chk("R3 space select", io_sel, io);
    chk("R6 strobes high in T1", {rd_n, wr_n}, 2'b11);
    // R7: disturb request fields after capture
    req_addr = ~addr; req_wr = ~wr; req_io = ~io; req_wdata = ~wd;
    ad_in = ~dev;
    step(); // T2
    chk("R2 ale low in T2", ale, 0);
    chk("R7 high address held", addr_hi, addr[15:8]);
    chk("R3 space held", io_sel, io);
    if (wr) begin
      chk("R4 write drive T2", {ad_oe, wr_n, rd_n}, 3'b101);
      chk("R4 write data T2", ad_out, wd);
    end else begin
      chk("R5 read release T2", {ad_oe, rd_n, wr_n}, 3'b001);
    end
    ad_in = dev;
    step(); // T3
    if (wr) begin
      chk("R4 write drive T3", {ad_oe, wr_n, rd_n}, 3'b101);
      chk("R4 write data T3", ad_out, wd);
    end else begin
      chk("R5 read release T3", {ad_oe, rd_n, wr_n}, 3'b001);
    end
    step(); // done
    ad_in = 8'h5A;
    chk("R8 done pulse", rsp_done, 1);
    chk("R5 R12 read byte", rsp_rdata, exp_rd);
    chk("R6 strobes high after", {rd_n, wr_n}, 2'b11);
    if (!hold_valid) req_valid = 1'b0;
    req_addr = addr; req_wr = wr; req_io = io; req_wdata = wd;
    step();
    chk("R8 done one cycle", rsp_done, 0);
    chk("R8 no start from done cycle", ale, 0);
  endtask

  task automatic t_reset();
    chk("R1 ale", ale, 0);
    chk("R1 strobes", {rd_n, wr_n}, 2'b11);
    chk("R1 ad_oe", ad_oe, 0);
    chk("R1 done", rsp_done, 0);
    chk("R1 rdata", rsp_rdata, 0);
    chk("R1 float_ack", float_ack, 0);
    chk("R1 io_sel", io_sel, 0);
    chk("R1 enables", {addr_hi_oe, ctl_oe}, 2'b11);
  endtask

  task automatic t_basic();
    run_cycle(1'b1, 1'b0, 16'h12C4, 8'hA5, 8'h00, 8'h00, 1'b0); // memory write
    run_cycle(1'b0, 1'b1, 16'h0033, 8'h00, 8'h96, 8'h96, 1'b0); // IO read
    run_cycle(1'b0, 1'b0, 16'hFFFF, 8'h00, 8'h3C, 8'h3C, 1'b0); // memory read, top
    run_cycle(1'b1, 1'b1, 16'h0000, 8'hFF, 8'h11, 8'h3C, 1'b0); // R12 write keeps byte
  endtask

  task automatic t_hold_valid();
    run_cycle(1'b0, 1'b0, 16'h8001, 8'h00, 8'hC3, 8'hC3, 1'b1);
    // valid stayed high: R8 next cycle starts one idle cycle later
    req_wr = 1'b1; req_wdata = 8'h77; req_addr = 16'h4242;
    step();
    chk("R8 restart after idle", ale, 1);
    req_valid = 1'b0;
    step(); step(); step();
    chk("R8 second done", rsp_done, 1);
    chk("R12 byte kept over write", rsp_rdata, 8'hC3);
    step();
  endtask

  task automatic t_float_idle();
    req_valid = 1'b1; req_wr = 1'b0; req_io = 1'b0; req_addr = 16'hBEEF;
    float_req = 1'b1;
    step();
    chk("R9 float_ack", float_ack, 1);
    chk("R9 enables low", {addr_hi_oe, ad_oe, ctl_oe}, 3'b000);
    chk("R9 request not started", ale, 0);
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R11 no start while floated", {ale, rsp_done}, 2'b00);
    end
    float_req = 1'b0;
    step();
    chk("R11 float_ack drops", float_ack, 0);
    chk("R11 enables back", {addr_hi_oe, ctl_oe}, 2'b11);
    chk("R11 not yet T1", ale, 0);
    step();
    chk("R11 pending starts", ale, 1);
    chk("R11 address", {addr_hi, ad_out}, 16'hBEEF);
    ad_in = 8'h42;
    step(); step(); step();
    chk("R11 done", rsp_done, 1);
    chk("R11 read byte", rsp_rdata, 8'h42);
    req_valid = 1'b0;
    step();
  endtask

  task automatic t_float_mid();
    req_valid = 1'b1; req_wr = 1'b1; req_io = 1'b0; req_addr = 16'h2468; req_wdata = 8'hE1;
    step(); // T1
    chk("R10 T1 started", ale, 1);
    float_req = 1'b1;
    step(); // T2
    chk("R10 no grant in T2", float_ack, 0);
    chk("R10 drive kept T2", {ad_oe, wr_n, ctl_oe}, 3'b101);
    step(); // T3
    chk("R10 no grant in T3", float_ack, 0);
    chk("R10 data kept T3", ad_out, 8'hE1);
    step();
    chk("R10 done with grant", {rsp_done, float_ack}, 2'b11);
    chk("R10 enables low", {addr_hi_oe, ad_oe, ctl_oe}, 3'b000);
    req_valid = 1'b0;
    step();
    float_req = 1'b0;
    step();
    chk("R11 released", float_ack, 0);
  endtask

  initial begin
    n_chk = 0; n_err = 0; finished = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_wr = 1'b0; req_io = 1'b0;
    req_addr = '0; req_wdata = '0; float_req = 1'b0; ad_in = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
    t_reset();
    t_basic();
    t_hold_valid();
    t_float_idle();
    t_float_mid();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule